// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block is a 512-word by 18-bit first-in first-out buffer that sits between two independent, free-running clocks. A producer pushes words on the write clock when the block reports room. A consumer takes words on the read clock. The read side is first-word-fall-through: the oldest stored word is placed on the output by itself, and a read request only removes it.

The write side reports three flags. The first shows that there is room. The second shows that half the buffer or more is in use. The third is a single flag that is high near either end of the buffer. Its two thresholds share one offset. That offset can be loaded from the low data bits after reset, but only before the first word goes in.

Reset is synchronous and active low. It must be held for four edges of each clock before the block comes back up. Output drive is not modelled as tri-state. A separate qualifier shows whether both output enables are active.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word is stored on a `wclk` rising edge only when `wr_en_a` is 1, `wr_en_b_n` is 0 and `in_rdy` is 1. `in_rdy` is 0 whenever 512 words are held, and a write attempted then is dropped.
- R2: A word is removed on an `rclk` rising edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_rdy` is 1. `dout_drv` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0.
- R3: After a word is written into an empty buffer, `out_rdy` rises and `dout` carries that word on the third `rclk` rising edge after the write edge. No read request is needed for this.
- R4: While `out_rdy` is 0, `dout` keeps the last word that was read.
- R5: With `rst_n` low, the `wclk` edges force `in_rdy` and `half_full` to 0 and `almost_flag` to 1, and the `rclk` edges force `out_rdy` to 0. The block only returns to operation if `rst_n` was low for at least 4 edges of each clock. After a shorter pulse, `in_rdy` stays 0.
- R6: After a complete reset, `in_rdy` is 0 after the first `wclk` rising edge with `rst_n` high and 1 after the second.
- R7: `half_full` is 1 when 256 or more words are held. Writes count on their own `wclk` edge; reads reach the count a few `wclk` edges later.
- R8: `almost_flag` is 1 when the held count is at or below the offset or at or above 512 minus the offset. The offset is 64 after reset.
- R9: After reset and before the first write, a `wclk` rising edge with `prog_n` = 0 loads `din[7:0]` as the offset. That one value sets both thresholds.
- R10: Once a word has been written, `prog_n` has no effect until the next reset.
- R11: Words leave in the order they were written, including when the storage addresses wrap past 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| wr_en_a | input | 1 | Write enable, active high |
| wr_en_b_n | input | 1 | Write enable, active low |
| prog_n | input | 1 | Offset load request, active low |
| din | input | 18 | Write data; bits 7..0 also carry the offset |
| in_rdy | output | 1 | Room available (write domain) |
| half_full | output | 1 | 256 or more words held (write domain) |
| almost_flag | output | 1 | Count near empty or near full (write domain) |
| rd_en_n | input | 1 | Read request, active low |
| oe_a_n | input | 1 | Output enable, active low |
| oe_b_n | input | 1 | Output enable, active low |
| dout | output | 18 | Oldest word (first-word-fall-through) |
| dout_drv | output | 1 | Output qualifier: both enables active |
| out_rdy | output | 1 | `dout` holds an unread word (read domain) |

## Verification
The bound checker checks the following on every cycle:
- the write pointer stays still while `in_rdy` is low;
- the pointer crossing the domains changes by at most one bit per edge;
- a word that is not taken stays on `dout` with `out_rdy` held high;
- `dout` stays frozen while `out_rdy` is low;
- `in_rdy` never rises before the reset sequencer has declared the write side live.

Several things are only visible through the bench scenarios:
- the exact three-edge latency of the first word;
- the flag thresholds at every fill level from 1 to 512, with the programmed offset and with the default;
- the refusal of a late offset load;
- the rejection of a short reset pulse;
- ordering across the address wrap.

// File: rtl/dcf_pkg.sv
// Shared helpers for the dual-clock FIFO.
// Assumes pointers are no wider than 32 bits; callers cast to their width.
package dcf_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_rst_seq.sv
// Reset qualifier for one clock domain.
// Counts consecutive rising edges with rst_n low. The domain is declared
// live only when rst_n is released after at least EDGES such edges.
// A shorter pulse leaves the domain idle until a complete reset.
module dcf_rst_seq #(
    parameter int EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic live
);
    localparam int CW = $clog2(EDGES + 1);

    logic [CW-1:0] cnt;

    // Count low edges while in reset; go live on a qualified release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= 1'b0;
            if (live)
                cnt <= CW'(1);
            else if (cnt >= CW'(EDGES))
                cnt <= CW'(EDGES);
            else
                cnt <= cnt + CW'(1);
        end else begin
            if (cnt == CW'(EDGES))
                live <= 1'b1;
            else
                cnt <= '0;
        end
    end
endmodule

// File: rtl/dcf_gsync.sv
// Two-flop synchronizer for a Gray-coded pointer bus.
// Assumes at most one bit of d changes between source edges.
module dcf_gsync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-domain control: accepts words, keeps the write pointer and
// computes the room, half and near-end flags from the write pointer and
// the synchronized read (consumed) pointer.
// Assumes PW = AW + 1 > OW, so the offset fits the count width.
module dcf_wr_ctl #(
    parameter int AW      = 9,
    parameter int OW      = 8,
    parameter int DEF_OFS = 64
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          wr_en_a,
    input  logic          wr_en_b_n,
    input  logic          prog_n,
    input  logic [OW-1:0] ofs_in,
    input  logic [AW:0]   rgray_s,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          in_rdy,
    output logic          half_full,
    output logic          almost_flag
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin, wnext, rbin, cnt_next;
    logic [OW-1:0] ofs;
    logic          wrote;

    // Next pointer and the count that will hold after this edge.
    always_comb begin
        wr_fire  = wr_en_a & ~wr_en_b_n & in_rdy;
        rbin     = PW'(dcf_pkg::gray2bin(32'(rgray_s)));
        wnext    = wbin + PW'(wr_fire);
        cnt_next = wnext - rbin;
        waddr    = wbin[AW-1:0];
    end

    // Pointer, flags and offset register.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin        <= '0;
            wgray       <= '0;
            in_rdy      <= 1'b0;
            half_full   <= 1'b0;
            almost_flag <= 1'b1;
            ofs         <= OW'(DEF_OFS);
            wrote       <= 1'b0;
        end else begin
            wbin        <= wnext;
            wgray       <= PW'(dcf_pkg::bin2gray(32'(wnext)));
            in_rdy      <= live && (cnt_next != PW'(DEPTH));
            half_full   <= cnt_next >= PW'(DEPTH / 2);
            almost_flag <= (cnt_next <= PW'(ofs)) ||
                           (cnt_next >= PW'(DEPTH) - PW'(ofs));
            if (wr_fire)
                wrote <= 1'b1;
            if (live && !prog_n && !wrote && !wr_fire)
                ofs <= ofs_in;
        end
    end
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-domain control with first-word-fall-through output.
// A fetch pointer fills the output register whenever it is empty or
// being emptied. A separate consumed pointer, advanced only by real
// reads, is what the write side sees, so a slot is never reused while
// its word still sits on the output.
module dcf_rd_ctl #(
    parameter int AW = 9,
    parameter int DW = 18
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          rd_en_n,
    input  logic          oe_a_n,
    input  logic          oe_b_n,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          out_rdy,
    output logic          dout_drv
);
    localparam int PW = AW + 1;

    logic [PW-1:0] fbin, cbin, wbin;
    logic          empty, rd_fire, load;

    // Empty test, read decode and output-stage load decision.
    always_comb begin
        wbin     = PW'(dcf_pkg::gray2bin(32'(wgray_s)));
        empty    = (fbin == wbin);
        dout_drv = ~oe_a_n & ~oe_b_n;
        rd_fire  = ~rd_en_n & dout_drv & out_rdy;
        load     = live & ~empty & (~out_rdy | rd_fire);
        raddr    = fbin[AW-1:0];
    end

    // Output register, fetch pointer and consumed pointer.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            fbin    <= '0;
            cbin    <= '0;
            rgray   <= '0;
            dout    <= '0;
            out_rdy <= 1'b0;
        end else begin
            if (load) begin
                dout    <= mem_q;
                fbin    <= fbin + PW'(1);
                out_rdy <= 1'b1;
            end else if (rd_fire) begin
                out_rdy <= 1'b0;
            end
            if (rd_fire) begin
                cbin  <= cbin + PW'(1);
                rgray <= PW'(dcf_pkg::bin2gray(32'(cbin + PW'(1))));
            end
        end
    end
endmodule

// File: rtl/dcfifo_pflag.sv
// Dual-clock FIFO, 2**AW words of DW bits, with first-word-fall-through
// output and programmable near-end flag.
// Assumes rst_n meets setup to both clocks and both clocks run freely.
// The storage array has no reset; only words written are ever read.
module dcfifo_pflag #(
    parameter int DW      = 18,
    parameter int AW      = 9,
    parameter int OW      = 8,
    parameter int DEF_OFS = 64,
    parameter int RST_EDG = 4
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wr_en_a,
    input  logic          wr_en_b_n,
    input  logic          prog_n,
    input  logic [DW-1:0] din,
    output logic          in_rdy,
    output logic          half_full,
    output logic          almost_flag,
    input  logic          rd_en_n,
    input  logic          oe_a_n,
    input  logic          oe_b_n,
    output logic [DW-1:0] dout,
    output logic          dout_drv,
    output logic          out_rdy
);
    localparam int DEPTH = 1 << AW;

    logic          w_live, r_live, wr_fire;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   w_gray, r_gray, w_gray_s, r_gray_s;
    logic [DW-1:0] mem_q;
    logic [DW-1:0] mem [DEPTH];

    dcf_rst_seq #(.EDGES(RST_EDG)) u_wrst (.clk(wclk), .rst_n(rst_n), .live(w_live));
    dcf_rst_seq #(.EDGES(RST_EDG)) u_rrst (.clk(rclk), .rst_n(rst_n), .live(r_live));

    dcf_gsync #(.W(AW + 1)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s));
    dcf_gsync #(.W(AW + 1)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s));

    dcf_wr_ctl #(.AW(AW), .OW(OW), .DEF_OFS(DEF_OFS)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .live(w_live),
        .wr_en_a(wr_en_a), .wr_en_b_n(wr_en_b_n), .prog_n(prog_n),
        .ofs_in(din[OW-1:0]), .rgray_s(r_gray_s),
        .wr_fire(wr_fire), .waddr(waddr), .wgray(w_gray),
        .in_rdy(in_rdy), .half_full(half_full), .almost_flag(almost_flag)
    );

    dcf_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .live(r_live),
        .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .wgray_s(w_gray_s), .mem_q(mem_q),
        .raddr(raddr), .rgray(r_gray), .dout(dout),
        .out_rdy(out_rdy), .dout_drv(dout_drv)
    );

    // Storage write port, write clock domain.
    always_ff @(posedge wclk) begin
        if (wr_fire)
            mem[waddr] <= din;
    end

    // Storage read port; the addressed word is stable before it is fetched.
    assign mem_q = mem[raddr];
endmodule

// File: rtl/dcf_chk.sv
// Assertion checker for dcfifo_pflag, attached by the bind below.
module dcf_chk #(
    parameter int PW = 10,
    parameter int DW = 18
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          in_rdy,
    input logic          wlive,
    input logic [PW-1:0] wgray,
    input logic          out_rdy,
    input logic [DW-1:0] dout,
    input logic          rd_en_n,
    input logic          oe_a_n,
    input logic          oe_b_n
);
    // R1: no pointer movement while the buffer reports no room.
    a_r1_no_write_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
        !in_rdy |=> $stable(wgray));

    // R11: the crossing pointer steps one Gray bit at a time.
    a_r11_gray_single_step: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R2: a word that is not taken stays presented.
    a_r2_no_read_when_blocked: assert property (@(posedge rclk) disable iff (!rst_n)
        (out_rdy && (rd_en_n || oe_a_n || oe_b_n)) |=> (out_rdy && $stable(dout)));

    // R4: output frozen while nothing is ready.
    a_r4_hold_last_word: assert property (@(posedge rclk) disable iff (!rst_n)
        (!out_rdy ##1 !out_rdy) |-> $stable(dout));

    // R6: room is only reported once the write side is live.
    a_r6_ready_after_live: assert property (@(posedge wclk) disable iff (!rst_n)
        in_rdy |-> wlive);
endmodule

bind dcfifo_pflag dcf_chk #(.PW(AW + 1), .DW(DW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .in_rdy(in_rdy), .wlive(w_live), .wgray(w_gray),
    .out_rdy(out_rdy), .dout(dout),
    .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n)
);

// File: tb/test_dcfifo_pflag.sv
// Self-checking bench: fills the buffer through every level with the
// programmed and the default offset, drains it, and wraps the addresses.
module test_dcfifo_pflag;
    localparam int DW    = 18;
    localparam int DEPTH = 512;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en_a = 1'b0, wr_en_b_n = 1'b1, prog_n = 1'b1;
    logic rd_en_n = 1'b1, oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic in_rdy, half_full, almost_flag, dout_drv, out_rdy;
    logic [DW-1:0] dout;

    always #4 wclk = ~wclk;                       // 125 MHz
    initial begin #3; forever #4 rclk = ~rclk; end // 125 MHz, offset phase

    dcfifo_pflag i_dcfifo_pflag (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_en_a(wr_en_a), .wr_en_b_n(wr_en_b_n), .prog_n(prog_n), .din(din),
        .in_rdy(in_rdy), .half_full(half_full), .almost_flag(almost_flag),
        .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .dout(dout), .dout_drv(dout_drv), .out_rdy(out_rdy)
    );

    int n_chk = 0, n_fail = 0, stored = 0, seq = 0;
    bit done = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] last_rd;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(k * 2731 + 5);
    endfunction

    // Full reset with R5 checks, release and R6 checks.
    task automatic full_reset();
        @(negedge wclk);
        rst_n = 0; wr_en_a = 0; prog_n = 1; rd_en_n = 1; oe_a_n = 1; oe_b_n = 1;
        repeat (6) @(negedge wclk);
        chk(in_rdy == 0, "R5 in_rdy in reset", in_rdy, 0);
        chk(half_full == 0, "R5 half_full in reset", half_full, 0);
        chk(almost_flag == 1, "R5 almost_flag in reset", almost_flag, 1);
        chk(out_rdy == 0, "R5 out_rdy in reset", out_rdy, 0);
        exp_q.delete();
        stored = 0;
        rst_n = 1;
        @(negedge wclk);
        chk(in_rdy == 0, "R6 in_rdy after first edge", in_rdy, 0);
        @(negedge wclk);
        chk(in_rdy == 1, "R6 in_rdy after second edge", in_rdy, 1);
    endtask

    // One write attempt; the model stores it only if there is room (R1).
    task automatic wr_word(input logic [DW-1:0] d);
        wr_en_a = 1; wr_en_b_n = 0; din = d;
        @(negedge wclk);
        wr_en_a = 0; wr_en_b_n = 1;
        if (stored < DEPTH) begin
            exp_q.push_back(d);
            stored++;
        end
    endtask

    task automatic chk_flags(input int x, input string areq);
        chk(half_full == (stored >= DEPTH / 2), "R7 half_full", half_full, stored);
        chk(almost_flag == ((stored <= x) || (stored >= DEPTH - x)), areq, almost_flag, stored);
        chk(in_rdy == (stored < DEPTH), "R1 in_rdy", in_rdy, stored);
    endtask

    task automatic fill(input int n, input int x, input string areq);
        for (int k = 0; k < n; k++) begin
            wr_word(pat(seq));
            seq++;
            chk_flags(x, areq);
        end
    endtask

    // Read n words at full rate and check their order (R11).
    task automatic drain(input int n);
        int got = 0;
        int guard = 0;
        @(negedge rclk);
        rd_en_n = 0; oe_a_n = 0; oe_b_n = 0;
        while (guard < n * 4 + 40) begin
            if (out_rdy) begin
                chk(dout == exp_q[0], "R11 read order", dout, exp_q[0]);
                last_rd = exp_q.pop_front();
                stored--;
                got++;
            end
            if (got == n) break;
            @(negedge rclk);
            guard++;
        end
        chk(got == n, "R11 words drained", got, n);
        @(posedge rclk);
        #1 rd_en_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        full_reset();

        // R5: a two-edge reset pulse must leave the block idle.
        @(negedge wclk); rst_n = 0;
        @(negedge wclk); @(negedge wclk); rst_n = 1;
        repeat (6) @(negedge wclk);
        chk(in_rdy == 0, "R5 short reset rejected", in_rdy, 0);

        // Phase A: program offset 10, then fill with it.
        full_reset();
        prog_n = 0; din = DW'(10);
        @(negedge wclk);
        prog_n = 1;
        chk(almost_flag == 1, "R9 flag at empty", almost_flag, 1);
        wr_word(pat(seq)); seq++;
        chk(almost_flag == 1, "R9 count 1 below offset", almost_flag, 1);
        // R3: output ready on the third read edge after the write edge.
        @(negedge rclk);
        chk(out_rdy == 0, "R3 not ready after 1 edge", out_rdy, 0);
        chk(dout_drv == 0, "R2 qualifier off", dout_drv, 0);
        @(negedge rclk);
        chk(out_rdy == 0, "R3 not ready after 2 edges", out_rdy, 0);
        @(negedge rclk);
        chk(out_rdy == 1, "R3 ready after 3 edges", out_rdy, 1);
        chk(dout == exp_q[0], "R3 first word", dout, exp_q[0]);
        // R10: late offset load must be ignored.
        @(negedge wclk);
        prog_n = 0; din = DW'(200);
        @(negedge wclk);
        prog_n = 1;
        // R2: request with one enable inactive does not read.
        @(negedge rclk);
        rd_en_n = 0; oe_a_n = 0; oe_b_n = 1;
        repeat (3) @(negedge rclk);
        chk(out_rdy == 1, "R2 blocked read keeps word", out_rdy, 1);
        chk(dout == exp_q[0], "R2 blocked read data", dout, exp_q[0]);
        chk(dout_drv == 0, "R2 qualifier with one enable", dout_drv, 0);
        rd_en_n = 1; oe_b_n = 0;
        #1 chk(dout_drv == 1, "R2 qualifier both enables", dout_drv, 1);
        @(negedge wclk);
        fill(DEPTH - 1, 10, "R10 offset stays 10");
        wr_word(DW'(18'h3FFFF));
        chk(in_rdy == 0, "R1 full after overrun attempt", in_rdy, 0);
        drain(DEPTH);
        repeat (4) begin
            @(negedge rclk);
            chk(out_rdy == 0, "R1 overrun word not stored", out_rdy, 0);
            chk(dout == last_rd, "R4 holds last word", dout, last_rd);
        end

        // Phase B: default offset, then wrap the addresses.
        full_reset();
        @(negedge wclk);
        fill(DEPTH, 64, "R8 default offset");
        drain(300);
        repeat (8) @(negedge wclk);
        chk_flags(64, "R8 after partial drain");
        fill(300, 64, "R8 refill past wrap");
        drain(DEPTH);
        repeat (8) @(negedge wclk);
        chk_flags(64, "R8 empty again");
        finish_run();
    end
endmodule